// File: doc/BRIEF.md
# Extended-Real Compare and Classify Unit

This block orders two 80-bit extended-precision values or classifies one of them. It produces the four condition-code bits that a floating-point stack machine uses for conditional branching. Each operand has a sign in bit 79, a 15-bit biased exponent in bits 78..64 and a 64-bit significand in bits 63..0. Bit 63 of the significand is the explicit integer bit, and bit 62 is the quiet bit of a NaN.

A request is a one-cycle `valid_i` strobe with `mode_i` selecting the operation. In compare mode (`mode_i`=0) the top operand is ordered against the second operand. In examine mode (`mode_i`=1) the top operand is classified, and an empty-register tag takes part in the classification. The result is registered and appears one clock after the strobe, together with an invalid-operation flag. Infinities are always ordered in the affine sense.

`cc_o` carries the condition code with bit 3 = C3, bit 2 = C2, bit 1 = C1 and bit 0 = C0.

Top module: `fcc_unit`

## Requirements
- R1: On the clock edge that samples `valid_i`=1, the block loads `cc_o` and `invalid_o` and drives `valid_o`=1 for one cycle. On an edge with `valid_i`=0, `valid_o` goes to 0 and `cc_o` and `invalid_o` keep their values.
- R2: In compare mode, when top > operand, `cc_o` is 4'b0000. When top < operand, `cc_o` is 4'b0001. C1 (bit 1) is always 0 in compare mode.
- R3: In compare mode, equal values give `cc_o` = 4'b1000, and +0 and -0 compare as equal.
- R4: In compare mode, when either operand is a NaN or an unsupported encoding, the pair is unordered and `cc_o` = 4'b1101.
- R5: Ordering is affine: -infinity is below every finite value, every finite value is below +infinity, and each infinity equals itself.
- R6: `invalid_o` is 1 after a compare in which either operand is a signalling NaN (bit 62 clear) or an unsupported encoding. A quiet NaN alone does not set it, and it is always 0 after an examine.
- R7: In examine mode, C1 equals the sign of the top operand. {C3,C2,C0} gives the class: unsupported 000, NaN 001, normal 010, infinity 011, zero 100, empty 101, denormal 110.
- R8: Classes are assigned as follows. A zero exponent with a zero significand is zero. A zero exponent with a non-zero significand is denormal, including when bit 63 is set. A non-zero exponent with bit 63 clear is unsupported. An all-ones exponent with bit 63 set is infinity if bits 62..0 are zero and a NaN otherwise. Everything else is normal.
- R9: In examine mode an asserted `top_empty_i` forces the empty class whatever the operand bits are. In compare mode `top_empty_i` has no effect.
- R10: Denormals are ordered by value. A denormal is below the smallest normal. A zero-exponent value with bit 63 set equals the exponent-1 value with the same significand.
- R11: After reset, `valid_o`, `cc_o` and `invalid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 1 | 0 = compare, 1 = examine |
| top_i | input | 80 | Top-of-stack operand |
| opnd_i | input | 80 | Second operand (compare only) |
| top_empty_i | input | 1 | Top register is tagged empty |
| valid_o | output | 1 | Result valid, one cycle after the strobe |
| cc_o | output | 4 | Condition code {C3,C2,C1,C0} |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
A misclassification inside the block is visible at `cc_o` in the cycle right after the strobe, because each class decision feeds the code directly. A wrong ordering key shows up as a swapped or false-equal order code. Such errors show best on neighbours such as a denormal against the smallest normal, the two zero signs, and a pseudo-denormal against its exponent-1 twin. A stale or wrongly enabled result register appears as a code that changes in a cycle without a strobe, or as a missing `valid_o` pulse.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int EXP_W = 15;
  localparam int MAN_W = 64;
  localparam int OP_W  = 1 + EXP_W + MAN_W;

  // {C3,C2,C0} class codes
  typedef enum logic [2:0] {
    CLS_UNSUP  = 3'b000,
    CLS_NAN    = 3'b001,
    CLS_NORM   = 3'b010,
    CLS_INF    = 3'b011,
    CLS_ZERO   = 3'b100,
    CLS_EMPTY  = 3'b101,
    CLS_DENORM = 3'b110
  } cls_e;

  // {C3,C2,C0} order codes
  localparam logic [2:0] ORD_GT    = 3'b000;
  localparam logic [2:0] ORD_LT    = 3'b001;
  localparam logic [2:0] ORD_EQ    = 3'b100;
  localparam logic [2:0] ORD_UNORD = 3'b111;
endpackage

// File: rtl/fcc_classify.sv
module fcc_classify
  import fcc_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W,
  localparam int OW = 1 + EW + MW,
  localparam int KW = EW + MW
) (
  input  logic [OW-1:0] op_i,
  output cls_e          cls_o,
  output logic          sign_o,
  output logic          snan_o,
  output logic [KW-1:0] key_o
);
  logic [EW-1:0] exp_f;
  logic [MW-1:0] man_f;
  logic          exp_zero, exp_max, jbit, frac_zero;

  assign exp_f     = op_i[MW +: EW];
  assign man_f     = op_i[MW-1:0];
  assign sign_o    = op_i[OW-1];
  assign exp_zero  = (exp_f == '0);
  assign exp_max   = &exp_f;
  assign jbit      = man_f[MW-1];
  assign frac_zero = (man_f[MW-2:0] == '0);

  always_comb begin
    if (exp_zero)     cls_o = (man_f == '0) ? CLS_ZERO : CLS_DENORM;
    else if (!jbit)   cls_o = CLS_UNSUP;
    else if (exp_max) cls_o = frac_zero ? CLS_INF : CLS_NAN;
    else              cls_o = CLS_NORM;
  end

  assign snan_o = (cls_o == CLS_NAN) && !man_f[MW-2];

  // zero exponent scales like exponent 1
  assign key_o = {(exp_zero ? EW'(1) : exp_f), man_f};
endmodule

// File: rtl/fcc_order.sv
module fcc_order
  import fcc_pkg::*;
#(
  parameter int KW = EXP_W + MAN_W
) (
  input  cls_e          cls_a_i,
  input  cls_e          cls_b_i,
  input  logic          sign_a_i,
  input  logic          sign_b_i,
  input  logic [KW-1:0] key_a_i,
  input  logic [KW-1:0] key_b_i,
  output logic [2:0]    ord_o
);
  logic unord, both_zero, mag_gt;

  assign unord = (cls_a_i == CLS_NAN) || (cls_a_i == CLS_UNSUP) ||
                 (cls_b_i == CLS_NAN) || (cls_b_i == CLS_UNSUP);
  assign both_zero = (cls_a_i == CLS_ZERO) && (cls_b_i == CLS_ZERO);
  assign mag_gt    = key_a_i > key_b_i;

  always_comb begin
    if (unord)                      ord_o = ORD_UNORD;
    else if (both_zero)             ord_o = ORD_EQ;
    else if (sign_a_i != sign_b_i)  ord_o = sign_a_i ? ORD_LT : ORD_GT;
    else if (key_a_i == key_b_i)    ord_o = ORD_EQ;
    else                            ord_o = (mag_gt ^ sign_a_i) ? ORD_GT : ORD_LT;
  end
endmodule

// File: rtl/fcc_unit.sv
module fcc_unit
  import fcc_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W,
  localparam int OW = 1 + EW + MW,
  localparam int KW = EW + MW,
  localparam int NOPS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          mode_i,
  input  logic [OW-1:0] top_i,
  input  logic [OW-1:0] opnd_i,
  input  logic          top_empty_i,
  output logic          valid_o,
  output logic [3:0]    cc_o,
  output logic          invalid_o
);
  logic [OW-1:0] ops    [NOPS];
  cls_e          cls    [NOPS];
  logic          sgn    [NOPS];
  logic          snan   [NOPS];
  logic [KW-1:0] key    [NOPS];

  assign ops[0] = top_i;
  assign ops[1] = opnd_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fcc_classify #(.EW(EW), .MW(MW)) u_cls (
      .op_i  (ops[g]),
      .cls_o (cls[g]),
      .sign_o(sgn[g]),
      .snan_o(snan[g]),
      .key_o (key[g])
    );
  end

  logic [2:0] ord;
  fcc_order #(.KW(KW)) u_ord (
    .cls_a_i (cls[0]),
    .cls_b_i (cls[1]),
    .sign_a_i(sgn[0]),
    .sign_b_i(sgn[1]),
    .key_a_i (key[0]),
    .key_b_i (key[1]),
    .ord_o   (ord)
  );

  logic [2:0] exam_cls;
  logic [3:0] cc_d;
  logic       inv_d;

  assign exam_cls = top_empty_i ? CLS_EMPTY : cls[0];

  always_comb begin
    if (mode_i) begin
      cc_d  = {exam_cls[2], exam_cls[1], sgn[0], exam_cls[0]};
      inv_d = 1'b0;
    end else begin
      cc_d  = {ord[2], ord[1], 1'b0, ord[0]};
      inv_d = snan[0] || snan[1] || (cls[0] == CLS_UNSUP) || (cls[1] == CLS_UNSUP);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      cc_o      <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        cc_o      <= cc_d;
        invalid_o <= inv_d;
      end
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(cc_o) && $stable(invalid_o)));
  p_cmp_c1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i) |=> !cc_o[1]);
  p_unord_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i) |=> (!cc_o[2] || (cc_o[3] && cc_o[0])));
  p_exam_noinv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i) |=> !invalid_o);
  p_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i && top_empty_i) |=> (cc_o[3] && !cc_o[2] && cc_o[0]));
endmodule

// File: tb/fcc_unit_bench.sv
`timescale 1ns/1ps
module fcc_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [79:0] top_i = '0;
  logic [79:0] opnd_i = '0;
  logic        top_empty_i = 1'b0;
  logic        valid_o;
  logic [3:0]  cc_o;
  logic        invalid_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  fcc_unit u_fcc_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .top_i(top_i), .opnd_i(opnd_i), .top_empty_i(top_empty_i),
    .valid_o(valid_o), .cc_o(cc_o), .invalid_o(invalid_o)
  );

  function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  localparam logic [63:0] J = 64'h8000_0000_0000_0000;
  logic [79:0] p_one, n_one, p_two, p_inf, n_inf, p_zero, n_zero, qnan, snan_v,
               unsup, denorm, min_norm, pseudo_dn, n_denorm;

  task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp_v);
    n_run++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp_v);
    end
  endtask

  // one request; result read at the following falling edge
  task automatic do_op(input string req, input logic md, input logic [79:0] a,
                       input logic [79:0] b, input logic emp,
                       input logic [3:0] ecc, input logic einv);
    @(negedge clk_i);
    valid_i = 1'b1; mode_i = md; top_i = a; opnd_i = b; top_empty_i = emp;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(req, {valid_o, cc_o, invalid_o}, {1'b1, ecc, einv});
  endtask

  task automatic t_reset;
    chk("R11", {valid_o, cc_o, invalid_o}, 6'b0);
  endtask

  task automatic t_order;
    do_op("R2 gt", 1'b0, p_two, p_one, 1'b0, 4'b0000, 1'b0);
    do_op("R2 lt", 1'b0, p_one, p_two, 1'b0, 4'b0001, 1'b0);
    do_op("R2 neg lt", 1'b0, n_one, p_one, 1'b0, 4'b0001, 1'b0);
    do_op("R2 neg mag", 1'b0, n_one, mk(1'b1, 15'd16384, J), 1'b0, 4'b0000, 1'b0);
    do_op("R3 eq", 1'b0, p_one, p_one, 1'b0, 4'b1000, 1'b0);
    do_op("R3 zeros", 1'b0, n_zero, p_zero, 1'b0, 4'b1000, 1'b0);
  endtask

  task automatic t_unord;
    do_op("R4 qnan", 1'b0, p_one, qnan, 1'b0, 4'b1101, 1'b0);
    do_op("R4 R6 snan", 1'b0, snan_v, p_one, 1'b0, 4'b1101, 1'b1);
    do_op("R4 R6 unsup", 1'b0, p_one, unsup, 1'b0, 4'b1101, 1'b1);
  endtask

  task automatic t_affine;
    do_op("R5 ninf lt", 1'b0, n_inf, n_one, 1'b0, 4'b0001, 1'b0);
    do_op("R5 pinf gt", 1'b0, p_inf, p_two, 1'b0, 4'b0000, 1'b0);
    do_op("R5 inf eq", 1'b0, p_inf, p_inf, 1'b0, 4'b1000, 1'b0);
  endtask

  task automatic t_denorm;
    do_op("R10 dn lt", 1'b0, denorm, min_norm, 1'b0, 4'b0001, 1'b0);
    do_op("R10 pseudo eq", 1'b0, pseudo_dn, min_norm, 1'b0, 4'b1000, 1'b0);
    do_op("R10 neg dn", 1'b0, n_denorm, n_zero, 1'b0, 4'b0001, 1'b0);
  endtask

  task automatic t_examine;
    do_op("R7 R8 unsup", 1'b1, unsup, '0, 1'b0, 4'b0000, 1'b0);
    do_op("R7 R6 nan", 1'b1, snan_v, '0, 1'b0, 4'b0001, 1'b0);
    do_op("R7 norm neg", 1'b1, n_one, '0, 1'b0, 4'b0110, 1'b0);
    do_op("R7 inf neg", 1'b1, n_inf, '0, 1'b0, 4'b0111, 1'b0);
    do_op("R7 zero", 1'b1, p_zero, '0, 1'b0, 4'b1000, 1'b0);
    do_op("R7 denorm", 1'b1, denorm, '0, 1'b0, 4'b1100, 1'b0);
    do_op("R8 pseudo dn", 1'b1, pseudo_dn, '0, 1'b0, 4'b1100, 1'b0);
    do_op("R8 pseudo inf", 1'b1, mk(1'b0, 15'h7fff, 64'h0), '0, 1'b0, 4'b0000, 1'b0);
  endtask

  task automatic t_empty;
    do_op("R9 empty", 1'b1, p_one, '0, 1'b1, 4'b1001, 1'b0);
    do_op("R9 empty neg", 1'b1, n_inf, '0, 1'b1, 4'b1011, 1'b0);
    do_op("R9 cmp ignores", 1'b0, p_two, p_one, 1'b1, 4'b0000, 1'b0);
  endtask

  task automatic t_hold;
    do_op("R1 load", 1'b0, p_one, p_two, 1'b0, 4'b0001, 1'b0);
    @(negedge clk_i);
    mode_i = 1'b0; top_i = snan_v; opnd_i = p_one;
    @(negedge clk_i);
    chk("R1 hold", {valid_o, cc_o, invalid_o}, {1'b0, 4'b0001, 1'b0});
  endtask

  initial begin
    p_one     = mk(1'b0, 15'd16383, J);
    n_one     = mk(1'b1, 15'd16383, J);
    p_two     = mk(1'b0, 15'd16384, J);
    p_inf     = mk(1'b0, 15'h7fff, J);
    n_inf     = mk(1'b1, 15'h7fff, J);
    p_zero    = mk(1'b0, 15'd0, 64'h0);
    n_zero    = mk(1'b1, 15'd0, 64'h0);
    qnan      = mk(1'b0, 15'h7fff, 64'hC000_0000_0000_0000);
    snan_v    = mk(1'b0, 15'h7fff, 64'hA000_0000_0000_0000);
    unsup     = mk(1'b0, 15'd16383, 64'h4000_0000_0000_0000);
    denorm    = mk(1'b0, 15'd0, 64'h1);
    n_denorm  = mk(1'b1, 15'd0, 64'h1);
    min_norm  = mk(1'b0, 15'd1, J);
    pseudo_dn = mk(1'b0, 15'd0, J);
    #3;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_order();
    t_unord();
    t_affine();
    t_denorm();
    t_examine();
    t_empty();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule